// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a queue of master commands and a bit-level I2C engine. Software or a host block pushes command words into an internal FIFO. Each word holds a data byte, a direction bit, a flag to end the transfer after the byte, and a flag to force a fresh start condition before the byte. The sequencer looks at the word at the head of the queue. It then chooses the bus conditions to send around the byte: a START, a repeated START, a STOP followed by a START, nothing at all, or a trailing STOP. It passes each step to the engine as a single job over a request/done handshake.

When the queue runs dry in the middle of a transfer that has not been ended, the sequencer asks the engine to hold SCL low and waits. It does not release the bus. A read command is refused in two cases: a broadcast (general call) transfer is active while special commands are enabled, or a remote master has a read request pending against this device. In either case the sequencer raises a one-cycle transmit-abort pulse and empties the queue. If it owns the bus at that moment, it closes the transfer with a STOP.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: While `job_req` is high and `job_done` is low, `job_req`, `job_op` and `job_data` keep their values into the next cycle. The `job_op` codes are START=1, repeated START=2, STOP=3, write byte=4, read byte=5.
- R2: A command word has the data byte in bits 7:0, the direction in bit 8 (1 = read), stop-after in bit 9 and restart-before in bit 10. A write job carries bits 7:0 of its word on `job_data`.
- R3: A read job drives `job_data` to zero, whatever data bits the word held.
- R4: When the sequencer does not own the bus (after reset or after a STOP), a command is preceded by a plain START.
- R5: With restart-before set and `cfg_restart_en` high, a repeated START precedes the byte even when the direction matches the previous command.
- R6: With restart-before clear and the bus owned, a repeated START is issued only if the direction differs from the previous command. Otherwise the byte job follows directly.
- R7: Whenever a repeated START is called for but `cfg_restart_en` is low, a STOP and then a START are issued instead.
- R8: With stop-after set, a STOP follows the byte. A command still queued then begins with a START.
- R9: With stop-after clear and the queue empty, `hold_scl_low` is high and `job_req` is low. A later entry continues the transfer with no extra condition.
- R10: An entry leaves the queue only when the engine completes its byte job. With the engine stalled, a full queue keeps `cmd_full` high.
- R11: A read at the head while `gcall_active` and `cfg_special_en` are both high raises `tx_abort` and flushes the queue. With `cfg_special_en` low, the read goes ahead.
- R12: A read at the head while `slv_rd_req` is high is dropped and raises `tx_abort`. A write in the same situation goes ahead.
- R13: `tx_abort` lasts one cycle. If the bus was owned at the abort, a STOP is issued and `hold_scl_low` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Push a command word into the queue |
| cmd_wr_data | input | DATA_W+3 | Command word |
| cmd_full | output | 1 | Queue is full |
| cfg_restart_en | input | 1 | Repeated START allowed |
| cfg_special_en | input | 1 | Special-command mode enabled |
| gcall_active | input | 1 | Current target is the general call address |
| slv_rd_req | input | 1 | Remote master read request pending |
| job_req | output | 1 | Job valid toward the bit engine |
| job_op | output | 3 | Job operation code |
| job_data | output | DATA_W | Byte for a write job |
| job_done | input | 1 | Engine has completed the current job |
| hold_scl_low | output | 1 | Stall request: keep SCL low |
| tx_abort | output | 1 | Transmit abort pulse |

## Verification
The assertions check four things on every cycle: jobs stay stable under handshake back-pressure, read jobs carry no data, the stall never overlaps a job request, and an abort always leaves the queue empty and lasts one cycle. Only the bench scenarios can show that the right sequence of conditions surrounds each byte. The bench sweeps every direction, stop and restart combination of two consecutive commands under both restart settings, and compares the result with a model of the condition rules. Separate scenarios cover the stall-and-resume path, back-pressure on a full queue, and the two abort causes with their exceptions.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_START  = 3'd1,
      OP_RSTART = 3'd2,
      OP_STOP   = 3'd3,
      OP_WRITE  = 3'd4,
      OP_READ   = 3'd5
   } bus_op_e;

   typedef enum logic [1:0] {
      PLAN_DATA,
      PLAN_START,
      PLAN_RSTART,
      PLAN_STOP_START
   } cond_plan_e;

   typedef enum logic [1:0] {
      DIR_NONE,
      DIR_WR,
      DIR_RD
   } prev_dir_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE_STOP,
      ST_START,
      ST_RSTART,
      ST_DATA,
      ST_POST_STOP
   } seq_state_e;
endpackage

// File: rtl/seq_cmd_fifo.sv
module seq_cmd_fifo #(
   parameter int WIDTH = 11,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   input  logic             flush,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 2) begin : g_depth_check
      $error("seq_cmd_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 4) begin : g_width_check
      $error("seq_cmd_fifo: WIDTH too small for a command word");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr, wr_ptr;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R10: occupancy never exceeds the configured depth
   assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
endmodule

// File: rtl/seq_cond_select.sv
module seq_cond_select
   import i2c_seq_pkg::*;
(
   input  logic       bus_owned,
   input  prev_dir_e  prev_dir,
   input  logic       head_is_read,
   input  logic       head_restart,
   input  logic       restart_en,
   output cond_plan_e plan
);
   prev_dir_e head_dir;
   logic      need_restart;

   assign head_dir     = head_is_read ? DIR_RD : DIR_WR;
   assign need_restart = head_restart || ((prev_dir != DIR_NONE) && (prev_dir != head_dir));

   always_comb begin
      if (!bus_owned)        plan = PLAN_START;
      else if (!need_restart) plan = PLAN_DATA;
      else if (restart_en)   plan = PLAN_RSTART;
      else                   plan = PLAN_STOP_START;
   end
endmodule

// File: rtl/i2c_cmd_sequencer.sv
module i2c_cmd_sequencer
   import i2c_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_en,
   input  logic [DATA_W+2:0] cmd_wr_data,
   output logic              cmd_full,
   input  logic              cfg_restart_en,
   input  logic              cfg_special_en,
   input  logic              gcall_active,
   input  logic              slv_rd_req,
   output logic              job_req,
   output logic [2:0]        job_op,
   output logic [DATA_W-1:0] job_data,
   input  logic              job_done,
   output logic              hold_scl_low,
   output logic              tx_abort
);
   localparam int CMD_W    = DATA_W + 3;
   localparam int DIR_BIT  = DATA_W;
   localparam int STOP_BIT = DATA_W + 1;
   localparam int RS_BIT   = DATA_W + 2;

   if (DATA_W < 1) begin : g_data_check
      $error("i2c_cmd_sequencer: DATA_W must be positive");
   end

   logic [CMD_W-1:0] head;
   logic             q_empty, q_pop, q_flush;
   logic             head_rd, head_stop, head_rs;
   logic             abort_now;
   logic             bus_owned;
   prev_dir_e        prev_dir;
   seq_state_e       state, state_nx;
   cond_plan_e       plan;

   seq_cmd_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (cmd_wr_en),
      .din   (cmd_wr_data),
      .pop   (q_pop),
      .flush (q_flush),
      .dout  (head),
      .empty (q_empty),
      .full  (cmd_full)
   );

   assign head_rd   = head[DIR_BIT];
   assign head_stop = head[STOP_BIT];
   assign head_rs   = head[RS_BIT];

   seq_cond_select u_cond (
      .bus_owned    (bus_owned),
      .prev_dir     (prev_dir),
      .head_is_read (head_rd),
      .head_restart (head_rs),
      .restart_en   (cfg_restart_en),
      .plan         (plan)
   );

   // Refusal of a read at the head of the queue
   assign abort_now = (state == ST_IDLE) && !q_empty && head_rd &&
                      (slv_rd_req || (gcall_active && cfg_special_en));
   assign q_flush   = abort_now;
   assign q_pop     = (state == ST_DATA) && job_done;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: begin
            if (!q_empty) begin
               if (abort_now) state_nx = bus_owned ? ST_POST_STOP : ST_IDLE;
               else begin
                  case (plan)
                     PLAN_START:      state_nx = ST_START;
                     PLAN_RSTART:     state_nx = ST_RSTART;
                     PLAN_STOP_START: state_nx = ST_PRE_STOP;
                     default:         state_nx = ST_DATA;
                  endcase
               end
            end
         end
         ST_PRE_STOP:  if (job_done) state_nx = ST_START;
         ST_START:     if (job_done) state_nx = ST_DATA;
         ST_RSTART:    if (job_done) state_nx = ST_DATA;
         ST_DATA:      if (job_done) state_nx = head_stop ? ST_POST_STOP : ST_IDLE;
         ST_POST_STOP: if (job_done) state_nx = ST_IDLE;
         default:      state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bus_owned <= 1'b0;
         prev_dir  <= DIR_NONE;
         tx_abort  <= 1'b0;
      end else begin
         state    <= state_nx;
         tx_abort <= abort_now;
         if (state == ST_DATA && job_done) begin
            bus_owned <= 1'b1;
            prev_dir  <= head_rd ? DIR_RD : DIR_WR;
         end else if ((state == ST_POST_STOP || state == ST_PRE_STOP) && job_done) begin
            bus_owned <= 1'b0;
            prev_dir  <= DIR_NONE;
         end
      end
   end

   always_comb begin
      job_req  = (state != ST_IDLE);
      job_data = '0;
      case (state)
         ST_PRE_STOP, ST_POST_STOP: job_op = OP_STOP;
         ST_START:  job_op = OP_START;
         ST_RSTART: job_op = OP_RSTART;
         ST_DATA: begin
            job_op = head_rd ? OP_READ : OP_WRITE;
            if (!head_rd) job_data = head[DATA_W-1:0];
         end
         default:   job_op = OP_NONE;
      endcase
   end

   assign hold_scl_low = (state == ST_IDLE) && bus_owned && q_empty;

   // R1: a pending job does not change until the engine completes it
   assert_job_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (job_req && !job_done) |=> (job_req && $stable(job_op) && $stable(job_data)));

   // R3: read jobs never carry data
   assert_read_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (job_req && job_op == OP_READ) |-> (job_data == '0));

   // R9: stalling and requesting a job are exclusive
   assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_scl_low |-> !job_req);

   // R11: an abort leaves the queue empty
   assert_abort_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> q_empty);

   // R13: abort indication is a single-cycle pulse
   assert_abort_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort);
endmodule

// File: tb/i2c_cmd_sequencer_bench.sv
module i2c_cmd_sequencer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam logic [2:0] E_START = 3'd1, E_RSTART = 3'd2, E_STOP = 3'd3,
                          E_WRITE = 3'd4, E_READ = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr_en = 1'b0;
   logic [DW+2:0] cmd_wr_data = '0;
   logic          cmd_full;
   logic          cfg_restart_en = 1'b1;
   logic          cfg_special_en = 1'b0;
   logic          gcall_active = 1'b0;
   logic          slv_rd_req = 1'b0;
   logic          job_req;
   logic [2:0]    job_op;
   logic [DW-1:0] job_data;
   logic          job_done = 1'b0;
   logic          hold_scl_low;
   logic          tx_abort;

   int checks = 0, errors = 0;
   bit eng_en = 1'b1;
   bit finished = 1'b0;

   logic [2:0]    log_op [32];
   logic [DW-1:0] log_dat[32];
   int            n_log = 0, n_abort = 0;
   logic [2:0]    exp_op [32];
   logic [DW-1:0] exp_dat[32];
   int            n_exp = 0;
   bit            m_owned = 1'b0;
   bit            m_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_cmd_sequencer #(.DATA_W(DW), .DEPTH(4)) u_i2c_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
      .cmd_full(cmd_full), .cfg_restart_en(cfg_restart_en), .cfg_special_en(cfg_special_en),
      .gcall_active(gcall_active), .slv_rd_req(slv_rd_req), .job_req(job_req),
      .job_op(job_op), .job_data(job_data), .job_done(job_done),
      .hold_scl_low(hold_scl_low), .tx_abort(tx_abort)
   );

   // Bit engine model: accepts one job per request, done pulse of one cycle
   initial begin
      forever begin
         @(negedge clk);
         if (tx_abort) n_abort++;
         if (job_done) job_done = 1'b0;
         else if (rst_n && eng_en && job_req && n_log < 32) begin
            log_op[n_log]  = job_op;
            log_dat[n_log] = job_data;
            n_log++;
            job_done = 1'b1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      job_done = 1'b0;
      repeat (2) @(negedge clk);
      n_log = 0; n_abort = 0; n_exp = 0;
      m_owned = 1'b0; m_prev = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic push_cmd(input logic [DW+2:0] w);
      @(negedge clk);
      cmd_wr_en = 1'b1;
      cmd_wr_data = w;
      @(negedge clk);
      cmd_wr_en = 1'b0;
   endtask

   task automatic add_exp(input logic [2:0] op, input logic [DW-1:0] d);
      exp_op[n_exp] = op;
      exp_dat[n_exp] = d;
      n_exp++;
   endtask

   // Reference model of the condition rules (R4 to R8)
   task automatic model_cmd(input logic [DW+2:0] w, input bit rs_en);
      bit dir = w[8];
      if (!m_owned) add_exp(E_START, '0);
      else if (w[10] || dir != m_prev) begin
         if (rs_en) add_exp(E_RSTART, '0);
         else begin add_exp(E_STOP, '0); add_exp(E_START, '0); end
      end
      if (dir) add_exp(E_READ, '0); else add_exp(E_WRITE, w[7:0]);
      if (w[9]) m_owned = 1'b0;
      else begin m_owned = 1'b1; m_prev = dir; end
      if (w[9]) add_exp(E_STOP, '0);
   endtask

   task automatic compare_log(input string req);
      bit ok = (n_log == n_exp);
      for (int i = 0; i < n_exp && i < 32; i++)
         if (log_op[i] !== exp_op[i] || log_dat[i] !== exp_dat[i]) ok = 1'b0;
      check(ok, req, "job sequence (length)", n_log, n_exp);
   endtask

   function automatic logic [DW+2:0] mk(input bit rs, input bit stp, input bit rd,
                                         input logic [DW-1:0] d);
      return {rs, stp, rd, d};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      check(job_req == 1'b0 && hold_scl_low == 1'b0 && tx_abort == 1'b0 && cmd_full == 1'b0,
            "R4", "reset outputs quiet", int'({job_req, hold_scl_low, tx_abort, cmd_full}), 0);

      // Sweep: two commands, all dir/stop/restart combos, both restart settings
      for (int rs = 0; rs < 2; rs++) begin
         for (int p = 0; p < 64; p++) begin
            logic [DW+2:0] w1, w2;
            w1 = mk(p[0], p[1], p[2], 8'(p * 37 + 5));
            w2 = mk(p[3], p[4], p[5], 8'(p * 11 + 200));
            do_reset();
            cfg_restart_en = rs[0];
            model_cmd(w1, rs[0]);
            model_cmd(w2, rs[0]);
            push_cmd(w1);
            push_cmd(w2);
            repeat (40) @(negedge clk);
            compare_log("R2/R3/R4/R5/R6/R7/R8");
            check(hold_scl_low == m_owned, "R9", "stall after sweep pair",
                  int'(hold_scl_low), int'(m_owned));
         end
      end
      cfg_restart_en = 1'b1;

      // R9: stall on empty queue, resume without extra condition
      do_reset();
      push_cmd(mk(0, 0, 0, 8'hA5));
      repeat (10) @(negedge clk);
      check(hold_scl_low == 1'b1 && job_req == 1'b0, "R9", "stall while queue empty",
            int'({hold_scl_low, job_req}), 2);
      model_cmd(mk(0, 0, 0, 8'hA5), 1'b1);
      model_cmd(mk(0, 1, 0, 8'h3C), 1'b1);
      push_cmd(mk(0, 1, 0, 8'h3C));
      repeat (12) @(negedge clk);
      compare_log("R9");
      check(hold_scl_low == 1'b0, "R9", "stall released after stop", int'(hold_scl_low), 0);

      // R10: stalled engine leaves queue full
      do_reset();
      eng_en = 1'b0;
      for (int i = 0; i < 4; i++) push_cmd(mk(0, 0, 0, 8'(i)));
      repeat (10) @(negedge clk);
      check(cmd_full == 1'b1, "R10", "queue held full while engine stalled", int'(cmd_full), 1);
      eng_en = 1'b1;
      repeat (30) @(negedge clk);
      check(cmd_full == 1'b0 && n_log == 5, "R10", "queue drains on accept", n_log, 5);

      // R11 and R13: general call read with special enabled
      do_reset();
      gcall_active = 1'b1;
      cfg_special_en = 1'b1;
      push_cmd(mk(0, 0, 0, 8'h55));
      repeat (8) @(negedge clk);
      push_cmd(mk(0, 1, 1, 8'hFF));
      repeat (12) @(negedge clk);
      add_exp(E_START, '0); add_exp(E_WRITE, 8'h55); add_exp(E_STOP, '0);
      compare_log("R13");
      check(n_abort == 1, "R11", "abort pulses on gcall read", n_abort, 1);
      check(hold_scl_low == 1'b0, "R13", "stall cleared after abort", int'(hold_scl_low), 0);
      cfg_special_en = 1'b0;
      n_log = 0; n_exp = 0; m_owned = 1'b0;
      model_cmd(mk(0, 1, 1, 8'hEE), 1'b1);
      push_cmd(mk(0, 1, 1, 8'hEE));
      repeat (12) @(negedge clk);
      compare_log("R11");
      check(n_abort == 1, "R11", "no abort with special cleared", n_abort, 1);
      gcall_active = 1'b0;

      // R12: read colliding with remote read request
      do_reset();
      slv_rd_req = 1'b1;
      push_cmd(mk(0, 1, 1, 8'h12));
      repeat (8) @(negedge clk);
      check(n_abort == 1 && n_log == 0, "R12", "read dropped on remote request",
            n_log, 0);
      model_cmd(mk(0, 1, 0, 8'h9A), 1'b1);
      push_cmd(mk(0, 1, 0, 8'h9A));
      repeat (12) @(negedge clk);
      compare_log("R12");
      check(n_abort == 1, "R12", "write proceeds during remote request", n_abort, 1);
      slv_rd_req = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule